// File: doc/BRIEF.md
# Dual-Clock Interprocessor Mailbox

This block couples a host processor and a coprocessor that run from unrelated clocks. Neither side can reach the other's memory. All traffic passes through two byte channels. The host-to-coprocessor channel holds a single byte. The coprocessor-to-host command channel holds a small queue of `CMD_DEPTH` bytes. Each side writes and reads at its own rate. Every flag that crosses between the clock domains travels as a Gray-coded pointer through a two-flop synchroniser. A one-entry channel therefore reduces to a plain toggle. Correctness does not depend on the ratio of the two clocks.

Bit `SYNC_BIT` of a coprocessor command chooses how that command is handshaked:

- **Bit clear (buffered):** the coprocessor may continue at once. Its busy flag rises only when the queue is full.
- **Bit set (synchronous):** the coprocessor stays busy after the command is accepted. The host clears this busy state by pulsing `h_done` once it has finished the work.

On both sides, a write to a busy channel is dropped and sets a sticky overrun bit.

The write side of each channel is a one-cycle strobe checked against a busy level. It is not a handshake. The read side is valid/ready. `*_rx_valid` stays high, with the data held stable, until the consumer raises `*_rx_ready`. The byte is taken on the clock edge where both are high. The consumer may hold `ready` low for any number of cycles, and nothing is lost.

Top module: `mbox_dual`

## Requirements
- R1: After each domain's asynchronous reset (active low), `h_rx_valid`, `c_rx_valid`, `h_tx_full`, `c_cmd_busy`, `h_tx_ovr` and `c_cmd_ovr` are all 0, and bytes pending before the reset are discarded.
- R2: A host write (`h_tx_wr`) while `h_tx_full` is 0 sets `h_tx_full` at that same host edge. The byte then appears on `c_rx_data` with `c_rx_valid` high.
- R3: Commands accepted from the coprocessor reach `h_rx_data` in the order written, with none lost or repeated, up to `CMD_DEPTH` (default 4) outstanding.
- R4: For commands whose bit 7 (`SYNC_BIT`) is 0, `c_cmd_busy` is 1 exactly when `CMD_DEPTH` accepted commands are still unread by the host.
- R5: Accepting a command with bit 7 set makes `c_cmd_busy` 1 from the next coprocessor edge. It stays 1 until the host has taken that command and pulsed `h_done`. An `h_done` pulse given before the host has taken the command has no effect.
- R6: A write while `h_tx_full` (host) or `c_cmd_busy` (coprocessor) is 1 is dropped, and the byte is never delivered. The overrun bit on that side (`h_tx_ovr` / `c_cmd_ovr`) is set at the same edge.
- R7: An overrun bit stays set until its clear strobe (`h_ovr_clr` / `c_ovr_clr`) is high at an edge. If a new overrun occurs at the same edge as a clear, the overrun bit is set.
- R8: `*_rx_valid` stays high and `*_rx_data` stays unchanged while `*_rx_ready` is low. Taking the last pending byte drops `*_rx_valid` at that edge.
- R9: At any clock ratio, the writer's busy/full flag falls within three writer edges after the reader takes the byte, and a written byte becomes valid to the reader within three reader edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host clock |
| h_rst_n | input | 1 | Host asynchronous reset, active low |
| h_tx_wr | input | 1 | Host write strobe to the outbound byte register |
| h_tx_data | input | DATA_W | Byte written by the host |
| h_tx_full | output | 1 | Outbound register holds a byte the coprocessor has not read |
| h_tx_ovr | output | 1 | Sticky: a host write was dropped |
| h_ovr_clr | input | 1 | Clears `h_tx_ovr` |
| h_rx_valid | output | 1 | A coprocessor command is waiting for the host |
| h_rx_ready | input | 1 | Host takes the waiting command |
| h_rx_data | output | DATA_W | Oldest waiting command |
| h_done | input | 1 | Host finished a synchronous command |
| c_clk | input | 1 | Coprocessor clock |
| c_rst_n | input | 1 | Coprocessor asynchronous reset, active low |
| c_cmd_wr | input | 1 | Coprocessor command write strobe |
| c_cmd_data | input | DATA_W | Command byte; bit `SYNC_BIT` selects synchronous handshake |
| c_cmd_busy | output | 1 | Queue full or synchronous command outstanding |
| c_cmd_ovr | output | 1 | Sticky: a coprocessor write was dropped |
| c_ovr_clr | input | 1 | Clears `c_cmd_ovr` |
| c_rx_valid | output | 1 | A host byte is waiting for the coprocessor |
| c_rx_ready | input | 1 | Coprocessor takes the waiting byte |
| c_rx_data | output | DATA_W | Waiting host byte |

## Verification
Some results are due within the writer's own domain:

- Full, busy and overrun change at the very edge that registers the write. The bench samples them at the next falling edge of that clock.
- A pop drops `rx_valid` at that same edge. The bench checks this one falling edge later.

Results that cross domains are due within two to three edges of the receiving clock. These are reader visibility and writer release. For them the bench polls at each falling edge of the receiving clock, with a small fixed limit, and counts a miss as a failure. Before any exact in-domain check, the bench waits a few cycles of both clocks. This lets the synchronised pointers settle, so a stale pointer is never taken for a design error.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_DATA_W   = 8;
  localparam int unsigned MBOX_CMD_DEPTH = 4;
  localparam int unsigned MBOX_SYNC_BIT = 7;
  localparam int unsigned MBOX_SYNC_STAGES = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 1
) (
  input  logic              w_clk,
  input  logic              w_rst_n,
  input  logic              w_en,
  input  logic [DATA_W-1:0] w_data,
  input  logic              w_hold,
  input  logic              w_ovr_clr,
  output logic              w_full,
  output logic              w_ovr,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic              r_ready,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data
);
  localparam int unsigned PW = $clog2(DEPTH) + 1;
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wbin_nxt, wgray, rgray_s, rbin_s, wfill;
  logic [PW-1:0] rbin, rbin_nxt, rgray, wgray_s, wbin_s;
  logic [IW-1:0] widx, ridx;
  logic blocked, w_acc, r_pop;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  generate
    if (DEPTH > 1) begin : g_multi
      assign widx = wbin[IW-1:0];
      assign ridx = rbin[IW-1:0];
    end else begin : g_single
      assign widx = '0;
      assign ridx = '0;
    end
  endgenerate

  mbox_sync #(.W(PW)) u_r2w (.clk(w_clk), .rst_n(w_rst_n), .d(rgray), .q(rgray_s));
  mbox_sync #(.W(PW)) u_w2r (.clk(r_clk), .rst_n(r_rst_n), .d(wgray), .q(wgray_s));

  // writer domain
  assign rbin_s   = gray2bin(rgray_s);
  assign wfill    = wbin - rbin_s;
  assign w_full   = (wfill == FULL_CNT);
  assign blocked  = w_full | w_hold;
  assign w_acc    = w_en & ~blocked;
  assign wbin_nxt = wbin + 1'b1;

  always_ff @(posedge w_clk) begin
    if (w_acc) mem[widx] <= w_data;
  end

  always_ff @(posedge w_clk or negedge w_rst_n) begin
    if (!w_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      w_ovr <= 1'b0;
    end else begin
      if (w_acc) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      w_ovr <= (w_ovr & ~w_ovr_clr) | (w_en & blocked);
    end
  end

  // reader domain
  assign wbin_s   = gray2bin(wgray_s);
  assign r_valid  = (rbin != wbin_s);
  assign r_pop    = r_valid & r_ready;
  assign rbin_nxt = rbin + 1'b1;
  assign r_data   = mem[ridx];

  always_ff @(posedge r_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (r_pop) begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end
endmodule

// File: rtl/mbox_dual.sv
module mbox_dual
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W    = MBOX_DATA_W,
  parameter int unsigned CMD_DEPTH = MBOX_CMD_DEPTH,
  parameter int unsigned SYNC_BIT  = MBOX_SYNC_BIT
) (
  input  logic              h_clk,
  input  logic              h_rst_n,
  input  logic              h_tx_wr,
  input  logic [DATA_W-1:0] h_tx_data,
  output logic              h_tx_full,
  output logic              h_tx_ovr,
  input  logic              h_ovr_clr,
  output logic              h_rx_valid,
  input  logic              h_rx_ready,
  output logic [DATA_W-1:0] h_rx_data,
  input  logic              h_done,
  input  logic              c_clk,
  input  logic              c_rst_n,
  input  logic              c_cmd_wr,
  input  logic [DATA_W-1:0] c_cmd_data,
  output logic              c_cmd_busy,
  output logic              c_cmd_ovr,
  input  logic              c_ovr_clr,
  output logic              c_rx_valid,
  input  logic              c_rx_ready,
  output logic [DATA_W-1:0] c_rx_data
);
  logic q_full, c_sync_pend, c_acc;
  logic h_owed, h_done_tgl, h_take_sync;
  logic done_s, done_q, done_pulse;

  mbox_chan #(.DATA_W(DATA_W), .DEPTH(1)) u_h2c (
    .w_clk(h_clk), .w_rst_n(h_rst_n), .w_en(h_tx_wr), .w_data(h_tx_data),
    .w_hold(1'b0), .w_ovr_clr(h_ovr_clr), .w_full(h_tx_full), .w_ovr(h_tx_ovr),
    .r_clk(c_clk), .r_rst_n(c_rst_n), .r_ready(c_rx_ready),
    .r_valid(c_rx_valid), .r_data(c_rx_data)
  );

  mbox_chan #(.DATA_W(DATA_W), .DEPTH(CMD_DEPTH)) u_c2h (
    .w_clk(c_clk), .w_rst_n(c_rst_n), .w_en(c_cmd_wr), .w_data(c_cmd_data),
    .w_hold(c_sync_pend), .w_ovr_clr(c_ovr_clr), .w_full(q_full), .w_ovr(c_cmd_ovr),
    .r_clk(h_clk), .r_rst_n(h_rst_n), .r_ready(h_rx_ready),
    .r_valid(h_rx_valid), .r_data(h_rx_data)
  );

  // host side: track a synchronous command that still owes completion
  assign h_take_sync = h_rx_valid & h_rx_ready & h_rx_data[SYNC_BIT];

  always_ff @(posedge h_clk or negedge h_rst_n) begin
    if (!h_rst_n) begin
      h_owed     <= 1'b0;
      h_done_tgl <= 1'b0;
    end else begin
      h_owed <= (h_owed & ~h_done) | h_take_sync;
      if (h_done & h_owed) h_done_tgl <= ~h_done_tgl;
    end
  end

  mbox_sync #(.W(1)) u_done (.clk(c_clk), .rst_n(c_rst_n), .d(h_done_tgl), .q(done_s));

  // coprocessor side: hold busy until completion toggle arrives
  assign done_pulse = done_s ^ done_q;
  assign c_cmd_busy = q_full | c_sync_pend;
  assign c_acc      = c_cmd_wr & ~c_cmd_busy;

  always_ff @(posedge c_clk or negedge c_rst_n) begin
    if (!c_rst_n) begin
      done_q      <= 1'b0;
      c_sync_pend <= 1'b0;
    end else begin
      done_q      <= done_s;
      c_sync_pend <= (c_sync_pend & ~done_pulse) | (c_acc & c_cmd_data[SYNC_BIT]);
    end
  end
endmodule

// File: rtl/mbox_dual_chk.sv
module mbox_dual_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_BIT = 7
) (
  input logic              h_clk,
  input logic              h_rst_n,
  input logic              h_tx_wr,
  input logic              h_tx_full,
  input logic              h_tx_ovr,
  input logic              h_ovr_clr,
  input logic              h_rx_valid,
  input logic              h_rx_ready,
  input logic [DATA_W-1:0] h_rx_data,
  input logic              c_clk,
  input logic              c_rst_n,
  input logic              c_cmd_wr,
  input logic [DATA_W-1:0] c_cmd_data,
  input logic              c_cmd_busy,
  input logic              c_cmd_ovr,
  input logic              c_ovr_clr,
  input logic              c_rx_valid,
  input logic              c_rx_ready,
  input logic [DATA_W-1:0] c_rx_data
);
  p_full_on_write_r2: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_tx_wr && !h_tx_full |=> h_tx_full);

  p_sync_busy_r5: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    c_cmd_wr && !c_cmd_busy && c_cmd_data[SYNC_BIT] |=> c_cmd_busy);

  p_ovr_host_r6: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_tx_wr && h_tx_full |=> h_tx_ovr);

  p_ovr_cop_r6: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    c_cmd_wr && c_cmd_busy |=> c_cmd_ovr);

  p_ovr_sticky_h_r7: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_tx_ovr && !h_ovr_clr |=> h_tx_ovr);

  p_ovr_sticky_c_r7: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    c_cmd_ovr && !c_ovr_clr |=> c_cmd_ovr);

  p_hold_h_r8: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_rx_valid && !h_rx_ready |=> h_rx_valid && $stable(h_rx_data));

  p_hold_c_r8: assert property (@(posedge c_clk) disable iff (!c_rst_n)
    c_rx_valid && !c_rx_ready |=> c_rx_valid && $stable(c_rx_data));
endmodule

bind mbox_dual mbox_dual_chk #(.DATA_W(DATA_W), .SYNC_BIT(SYNC_BIT)) u_chk (
  .h_clk(h_clk), .h_rst_n(h_rst_n), .h_tx_wr(h_tx_wr), .h_tx_full(h_tx_full),
  .h_tx_ovr(h_tx_ovr), .h_ovr_clr(h_ovr_clr), .h_rx_valid(h_rx_valid),
  .h_rx_ready(h_rx_ready), .h_rx_data(h_rx_data), .c_clk(c_clk), .c_rst_n(c_rst_n),
  .c_cmd_wr(c_cmd_wr), .c_cmd_data(c_cmd_data), .c_cmd_busy(c_cmd_busy),
  .c_cmd_ovr(c_cmd_ovr), .c_ovr_clr(c_ovr_clr), .c_rx_valid(c_rx_valid),
  .c_rx_ready(c_rx_ready), .c_rx_data(c_rx_data)
);

// File: tb/sim_mbox_dual.sv
`timescale 1ns/1ps
module sim_mbox_dual;
  localparam int DEPTH = 4;
  // {coprocessor half period ns, seed, command count}
  localparam logic [23:0] VECS [6] = '{
    24'h03_10_04, 24'h05_20_02, 24'h0B_31_04,
    24'h17_40_01, 24'h28_55_03, 24'h40_6A_04
  };

  logic h_clk = 0, c_clk = 0;
  logic h_rst_n = 0, c_rst_n = 0;
  logic h_tx_wr = 0, h_ovr_clr = 0, h_rx_ready = 0, h_done = 0;
  logic [7:0] h_tx_data = 0;
  logic c_cmd_wr = 0, c_ovr_clr = 0, c_rx_ready = 0;
  logic [7:0] c_cmd_data = 0;
  logic h_tx_full, h_tx_ovr, h_rx_valid, c_cmd_busy, c_cmd_ovr, c_rx_valid;
  logic [7:0] h_rx_data, c_rx_data;
  realtime c_half = 5.0;
  int n_chk = 0, n_bad = 0, wd = 0;

  always #4 h_clk = ~h_clk;
  always #(c_half) c_clk = ~c_clk;

  mbox_dual u0 (
    .h_clk(h_clk), .h_rst_n(h_rst_n), .h_tx_wr(h_tx_wr), .h_tx_data(h_tx_data),
    .h_tx_full(h_tx_full), .h_tx_ovr(h_tx_ovr), .h_ovr_clr(h_ovr_clr),
    .h_rx_valid(h_rx_valid), .h_rx_ready(h_rx_ready), .h_rx_data(h_rx_data),
    .h_done(h_done), .c_clk(c_clk), .c_rst_n(c_rst_n), .c_cmd_wr(c_cmd_wr),
    .c_cmd_data(c_cmd_data), .c_cmd_busy(c_cmd_busy), .c_cmd_ovr(c_cmd_ovr),
    .c_ovr_clr(c_ovr_clr), .c_rx_valid(c_rx_valid), .c_rx_ready(c_rx_ready),
    .c_rx_data(c_rx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic h_wr(input logic [7:0] b, input logic clr);
    @(negedge h_clk); h_tx_wr = 1; h_tx_data = b; h_ovr_clr = clr;
    @(negedge h_clk); h_tx_wr = 0; h_ovr_clr = 0;
  endtask

  task automatic h_clr();
    @(negedge h_clk); h_ovr_clr = 1;
    @(negedge h_clk); h_ovr_clr = 0;
  endtask

  task automatic c_wr(input logic [7:0] b);
    @(negedge c_clk); c_cmd_wr = 1; c_cmd_data = b;
    @(negedge c_clk); c_cmd_wr = 0;
  endtask

  task automatic c_clr();
    @(negedge c_clk); c_ovr_clr = 1;
    @(negedge c_clk); c_ovr_clr = 0;
  endtask

  task automatic h_pop(input logic [7:0] exp, input string req);
    @(negedge h_clk);
    for (int n = 0; n < 12 && !h_rx_valid; n++) @(negedge h_clk);
    chk(h_rx_valid, req, h_rx_valid, 1);
    chk(h_rx_data == exp, req, h_rx_data, exp);
    h_rx_ready = 1;
    @(negedge h_clk); h_rx_ready = 0;
  endtask

  task automatic c_pop(input logic [7:0] exp, input string req);
    @(negedge c_clk);
    for (int n = 0; n < 12 && !c_rx_valid; n++) @(negedge c_clk);
    chk(c_rx_valid, req, c_rx_valid, 1);
    chk(c_rx_data == exp, req, c_rx_data, exp);
    c_rx_ready = 1;
    @(negedge c_clk); c_rx_ready = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge c_clk);
    repeat (4) @(negedge h_clk);
  endtask

  task automatic wait_h_free(input string req);
    @(negedge h_clk);
    for (int n = 0; n < 6 && h_tx_full; n++) @(negedge h_clk);
    chk(!h_tx_full, req, h_tx_full, 0);
  endtask

  task automatic wait_c_free(input string req);
    @(negedge c_clk);
    for (int n = 0; n < 6 && c_cmd_busy; n++) @(negedge c_clk);
    chk(!c_cmd_busy, req, c_cmd_busy, 0);
  endtask

  task automatic pulse_done();
    @(negedge h_clk); h_done = 1;
    @(negedge h_clk); h_done = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge h_clk) begin
    wd++;
    if (wd > 150000) begin
      chk(0, "watchdog", wd, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge h_clk);
    h_rst_n = 1; c_rst_n = 1;
    settle();
    // R1 reset state
    chk(!h_rx_valid && !c_rx_valid, "R1 valid", {h_rx_valid, c_rx_valid}, 0);
    chk(!h_tx_full && !c_cmd_busy, "R1 busy", {h_tx_full, c_cmd_busy}, 0);
    chk(!h_tx_ovr && !c_cmd_ovr, "R1 ovr", {h_tx_ovr, c_cmd_ovr}, 0);

    // vector walk over clock ratios
    for (int v = 0; v < 6; v++) begin
      logic [7:0] seed, cnt;
      c_half = VECS[v][23:16];
      seed = VECS[v][15:8];
      cnt  = VECS[v][7:0];
      settle();
      for (int i = 0; i < int'(cnt); i++) c_wr((seed + 8'(i)) & 8'h7F);
      chk(c_cmd_busy == (int'(cnt) == DEPTH), "R4 busy level", c_cmd_busy, int'(cnt) == DEPTH);
      for (int i = 0; i < int'(cnt); i++) h_pop((seed + 8'(i)) & 8'h7F, "R3 order");
      wait_c_free("R9 busy release");
      h_wr(~seed, 0);
      chk(h_tx_full, "R2 full on write", h_tx_full, 1);
      c_pop(~seed, "R2 delivery");
      wait_h_free("R9 full release");
    end
    c_half = 7.0;
    settle();

    // R6/R7 host overrun, clear and set-wins
    h_wr(8'h5A, 0);
    h_wr(8'h5B, 0);
    chk(h_tx_ovr, "R6 host overrun", h_tx_ovr, 1);
    h_clr();
    chk(!h_tx_ovr, "R7 clear", h_tx_ovr, 0);
    h_wr(8'h5C, 1);
    chk(h_tx_ovr, "R7 set wins", h_tx_ovr, 1);
    h_clr();
    c_pop(8'h5A, "R6 kept byte");
    settle();
    chk(!c_rx_valid, "R6 dropped bytes", c_rx_valid, 0);

    // R6/R7 coprocessor overrun on full queue
    for (int i = 1; i <= DEPTH + 1; i++) c_wr(8'(i));
    chk(c_cmd_ovr, "R6 queue overrun", c_cmd_ovr, 1);
    for (int i = 1; i <= DEPTH; i++) h_pop(8'(i), "R3 after overrun");
    settle();
    chk(!h_rx_valid, "R6 fifth dropped", h_rx_valid, 0);
    c_clr();
    chk(!c_cmd_ovr, "R7 cop clear", c_cmd_ovr, 0);

    // R5 synchronous command
    c_wr(8'h85);
    chk(c_cmd_busy, "R5 busy after sync", c_cmd_busy, 1);
    settle();
    pulse_done();
    repeat (6) @(negedge c_clk);
    chk(c_cmd_busy, "R5 early done ignored", c_cmd_busy, 1);
    c_wr(8'h22);
    chk(c_cmd_ovr, "R6 write while sync pending", c_cmd_ovr, 1);
    c_clr();
    h_pop(8'h85, "R5 sync delivery");
    repeat (8) @(negedge c_clk);
    chk(c_cmd_busy, "R5 busy until done", c_cmd_busy, 1);
    pulse_done();
    wait_c_free("R5 release on done");
    settle();
    chk(!h_rx_valid, "R6 pending write dropped", h_rx_valid, 0);

    // R8 hold while not ready
    c_wr(8'h11);
    settle();
    for (int i = 0; i < 5; i++) begin
      @(negedge h_clk);
      chk(h_rx_valid && h_rx_data == 8'h11, "R8 hold", h_rx_data, 8'h11);
    end
    h_rx_ready = 1;
    @(negedge h_clk); h_rx_ready = 0;
    chk(!h_rx_valid, "R8 valid drops", h_rx_valid, 0);

    // R1 reset discards pending bytes
    c_wr(8'h33);
    h_wr(8'h44, 0);
    settle();
    h_rst_n = 0; c_rst_n = 0;
    repeat (2) @(negedge h_clk);
    h_rst_n = 1; c_rst_n = 1;
    settle();
    chk(!h_rx_valid && !c_rx_valid, "R1 discard", {h_rx_valid, c_rx_valid}, 0);
    chk(!h_tx_full && !c_cmd_busy, "R1 flags", {h_tx_full, c_cmd_busy}, 0);

    finish_run();
  end
endmodule